// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Bank

This block holds the interrupt state and the channel enables of a multi-channel DMA controller. The channel engines send single-cycle event pulses for five interrupt classes: transfer done, block done, source transaction, destination transaction and error. Each pulse sets a raw latch for its channel and class. A per-class mask selects which latched events reach the interrupt outputs. There is one registered interrupt line per class and one combined line.

Software reaches the bank through a simple word-addressed bus with address, write data, write strobe and registered read data. The mask and channel-enable registers carry a per-channel write-enable field in write-data bits [NCH+7:8]. A single write therefore changes only the channels it names, and software never needs a read-modify-write. Each raw latch is cleared by writing ones to a clear port. A channel's enable bit drops by itself when that channel's engine reports that it is done.

Top module: `dmairq_regs`

## Requirements
- R1: After a synchronous reset, every register reads 0. `irq_cls`, `irq_any`, `ch_en_o` and `ctrl_en_o` are also 0.
- R2: Bit `c*NCH+ch` of `ev_pulse` sets channel ch's raw latch for class c. The class order is transfer=0, block=1, source=2, destination=3, error=4. The latch is visible at word address c (bit ch) after the clock edge that samples the pulse.
- R3: Word address 5+c reads the status of class c. The status is the bitwise AND of the raw latches and the mask of class c.
- R4: A write to mask word 10+c loads bit ch from wdata[ch] only when wdata[ch+8] is 1. Other channels keep their mask. Bits above NCH-1 read as 0.
- R5: Writing 1 to bit ch of clear word 15+c clears that raw latch. Writing 0 has no effect. If an event pulse arrives in the same cycle as the clear, the event wins and the latch stays set.
- R6: `irq_cls[c]` is the OR of class c's status bits, registered one cycle after the raw and mask state. `irq_any` is the OR of all status bits, with the same timing.
- R7: Word address 20 reads the combined status: bit c is 1 when class c has any pending, unmasked event.
- R8: Word address 21 is the global enable. A write loads wdata[0] into `ctrl_en_o`, and a read returns it in bit 0.
- R9: Word address 22 is the channel enable, and it uses the same write-enable scheme as R4. `ch_done[ch]` clears enable bit ch, unless a write in the same cycle has wdata[ch+8] set; in that case the written value wins.
- R10: `bus_rdata` shows the word at the address sampled on the previous edge. Writes to raw, status, combined or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Registered read data |
| ev_pulse | input | 5*NCH | Event pulses, bit c*NCH+ch |
| ch_done | input | NCH | Per-channel completion pulses |
| irq_cls | output | 5 | Per-class interrupt |
| irq_any | output | 1 | Combined interrupt |
| ch_en_o | output | NCH | Channel enables |
| ctrl_en_o | output | 1 | Global controller enable |

## Verification
Directed writes exercise the write-enable field in three ways: enable set with value 1, enable set with value 0, and value bits set with the enable clear. These cases show that only the named channels change. Clears are tried with zero data, with a matching bit, and together with a same-cycle event; channel enables are tried with a completion pulse alone and together with a same-cycle start write. Together these cases confirm both collision priorities. A long stretch of random addresses, writes, sparse events and done pulses is then compared every cycle against a behavioural model. The random stretch covers class and channel combinations that the directed cases skip.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned NCLS      = 5;
  localparam int unsigned OFS_RAW   = 0;
  localparam int unsigned OFS_STAT  = NCLS;
  localparam int unsigned OFS_MASK  = 2 * NCLS;
  localparam int unsigned OFS_CLR   = 3 * NCLS;
  localparam int unsigned OFS_COMB  = 4 * NCLS;
  localparam int unsigned OFS_CFG   = 4 * NCLS + 1;
  localparam int unsigned OFS_CHEN  = 4 * NCLS + 2;
  localparam int unsigned WE_LSB    = 8;
endpackage

// File: rtl/dmairq_class.sv
module dmairq_class #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] ev,
  input  logic           mask_wr,
  input  logic           clr_wr,
  input  logic [NCH-1:0] wr_en,
  input  logic [NCH-1:0] wr_val,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] stat_o,
  output logic           irq_q
);
  logic [NCH-1:0] clr_bits;

  assign clr_bits = clr_wr ? wr_val : '0;
  assign stat_o   = raw_q & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      // the event is ORed in after the clear, so it wins a collision
      raw_q <= (raw_q & ~clr_bits) | ev;
      if (mask_wr) mask_q <= (mask_q & ~wr_en) | (wr_val & wr_en);
      irq_q <= |stat_o;
    end
  end
endmodule

// File: rtl/dmairq_chen.sv
module dmairq_chen #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [NCH-1:0] wr_en,
  input  logic [NCH-1:0] wr_val,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] en_q
);
  logic [NCH-1:0] after_done;
  logic [NCH-1:0] sel;

  assign after_done = en_q & ~done;
  assign sel        = wr ? wr_en : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (after_done & ~sel) | (wr_val & sel);
  end
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NCLS*NCH-1:0]  ev_pulse,
  input  logic [NCH-1:0]       ch_done,
  output logic [NCLS-1:0]      irq_cls,
  output logic                 irq_any,
  output logic [NCH-1:0]       ch_en_o,
  output logic                 ctrl_en_o
);
  localparam int unsigned NWORDS = OFS_CHEN + 1;

  initial begin
    if (NCH < 1 || NCH > 8) $error("NCH must be 1..8");
    if ((1 << ADDR_W) < NWORDS) $error("ADDR_W too small");
    if (DATA_W < 16) $error("DATA_W must be at least 16");
  end

  int unsigned    a_u;
  logic [NCH-1:0] wr_en, wr_val;
  logic [NCH-1:0] raw_a  [NCLS];
  logic [NCH-1:0] mask_a [NCLS];
  logic [NCH-1:0] stat_a [NCLS];
  logic [NCLS*NCH-1:0] raw_flat;
  logic [NCLS-1:0] pend;
  logic            unused_wd;

  assign a_u       = 32'(bus_addr);
  assign wr_val    = bus_wdata[NCH-1:0];
  assign wr_en     = bus_wdata[WE_LSB +: NCH];
  assign unused_wd = ^bus_wdata;

  for (genvar c = 0; c < int'(NCLS); c++) begin : g_cls
    logic mwr, cwr;
    assign mwr = bus_we && (a_u == OFS_MASK + c);
    assign cwr = bus_we && (a_u == OFS_CLR + c);
    dmairq_class #(.NCH(NCH)) u_cls (
      .clk(clk), .rst(rst), .ev(ev_pulse[c*NCH +: NCH]),
      .mask_wr(mwr), .clr_wr(cwr), .wr_en(wr_en), .wr_val(wr_val),
      .raw_q(raw_a[c]), .mask_q(mask_a[c]), .stat_o(stat_a[c]),
      .irq_q(irq_cls[c])
    );
    assign raw_flat[c*NCH +: NCH] = raw_a[c];
    assign pend[c] = |stat_a[c];
  end

  dmairq_chen #(.NCH(NCH)) u_chen (
    .clk(clk), .rst(rst), .wr(bus_we && (a_u == OFS_CHEN)),
    .wr_en(wr_en), .wr_val(wr_val), .done(ch_done), .en_q(ch_en_o)
  );

  logic [DATA_W-1:0] rd_d;
  logic [2:0]        sub;

  always_comb begin
    rd_d = '0;
    sub  = '0;
    if (a_u < OFS_STAT) begin
      sub  = 3'(a_u - OFS_RAW);
      rd_d = DATA_W'(raw_a[sub]);
    end else if (a_u < OFS_MASK) begin
      sub  = 3'(a_u - OFS_STAT);
      rd_d = DATA_W'(stat_a[sub]);
    end else if (a_u < OFS_CLR) begin
      sub  = 3'(a_u - OFS_MASK);
      rd_d = DATA_W'(mask_a[sub]);
    end else if (a_u == OFS_COMB) begin
      rd_d = DATA_W'(pend);
    end else if (a_u == OFS_CFG) begin
      rd_d = DATA_W'(ctrl_en_o);
    end else if (a_u == OFS_CHEN) begin
      rd_d = DATA_W'(ch_en_o);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_any   <= 1'b0;
      ctrl_en_o <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      irq_any   <= |pend;
      if (bus_we && (a_u == OFS_CFG)) ctrl_en_o <= bus_wdata[0];
    end
  end
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
  import dmairq_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic                cfg_bit,
  input logic [NCLS*NCH-1:0] ev_pulse,
  input logic [NCLS*NCH-1:0] raw_flat,
  input logic [NCH-1:0]      ch_done,
  input logic [NCLS-1:0]     irq_cls,
  input logic                irq_any,
  input logic [NCH-1:0]      ch_en_o,
  input logic                ctrl_en_o
);
  // R1
  rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_cls == '0 && !irq_any && ch_en_o == '0 && !ctrl_en_o));

  // R2
  ev_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_pulse != '0) |=> ((raw_flat & $past(ev_pulse)) == $past(ev_pulse)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_any) |-> $past(raw_flat != '0));

  // R8
  cfg_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_CFG)) |=> (ctrl_en_o == $past(cfg_bit)));

  // R9
  done_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((ch_done != '0) && !(bus_we && bus_addr == ADDR_W'(OFS_CHEN)))
      |=> ((ch_en_o & $past(ch_done)) == '0));
endmodule

bind dmairq_regs dmairq_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .cfg_bit(bus_wdata[0]), .ev_pulse(ev_pulse), .raw_flat(raw_flat),
  .ch_done(ch_done), .irq_cls(irq_cls), .irq_any(irq_any),
  .ch_en_o(ch_en_o), .ctrl_en_o(ctrl_en_o)
);

// File: tb/test_dmairq_regs.sv
module test_dmairq_regs;
  localparam int PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 0, rst = 1, we = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [19:0] ev = 0;
  logic [3:0]  done = 0;
  logic [31:0] rdata;
  logic [4:0]  irq;
  logic        any, cen;
  logic [3:0]  chen;

  dmairq_regs #(.NCH(NCH), .ADDR_W(5), .DATA_W(32)) i_dmairq_regs (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .ev_pulse(ev), .ch_done(done), .irq_cls(irq),
    .irq_any(any), .ch_en_o(chen), .ctrl_en_o(cen)
  );

  always #(PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  string cur_req = "R1";
  bit ended = 0;

  // behavioural model
  int m_raw[5], m_mask[5];
  int m_chen = 0, m_cfg = 0;
  logic [31:0] e_rd = 0;
  logic [4:0]  e_irq = 0;
  logic        e_any = 0;

  function automatic int mread(int a);
    int comb = 0;
    for (int c = 0; c < 5; c++) if ((m_raw[c] & m_mask[c]) != 0) comb |= (1 << c);
    if (a < 5)  return m_raw[a];
    if (a < 10) return m_raw[a-5] & m_mask[a-5];
    if (a < 15) return m_mask[a-10];
    if (a < 20) return 0;
    if (a == 20) return comb;
    if (a == 21) return m_cfg;
    if (a == 22) return m_chen;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 5; c++) begin m_raw[c] = 0; m_mask[c] = 0; end
      m_chen = 0; m_cfg = 0; e_rd = 0; e_irq = 0; e_any = 0;
    end else begin
      int a, en, val;
      a = int'(addr);
      en = int'((wdata >> 8) & 32'hF);
      val = int'(wdata & 32'hF);
      e_rd = 32'(mread(a));
      for (int c = 0; c < 5; c++) e_irq[c] = ((m_raw[c] & m_mask[c]) != 0);
      e_any = (e_irq != 0);
      m_chen = m_chen & ~int'(done);
      if (we) begin
        if (a >= 10 && a < 15) m_mask[a-10] = (m_mask[a-10] & ~en) | (val & en);
        else if (a >= 15 && a < 20) m_raw[a-15] = m_raw[a-15] & ~val;
        else if (a == 21) m_cfg = int'(wdata[0]);
        else if (a == 22) m_chen = (m_chen & ~en) | (val & en);
      end
      for (int c = 0; c < 5; c++) m_raw[c] |= int'((ev >> (4*c)) & 20'hF);
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(rdata, e_rd, "rdata");
    chk(32'(irq), 32'(e_irq), "irq_cls");
    chk(32'(any), 32'(e_any), "irq_any");
    chk(32'(chen), 32'(m_chen), "ch_en");
    chk(32'(cen), 32'(m_cfg), "ctrl_en");
  end

  task automatic cyc(input logic w, input int a, input logic [31:0] d,
                     input logic [19:0] e, input logic [3:0] dn);
    @(negedge clk);
    we = w; addr = 5'(a); wdata = d; ev = e; done = dn;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string what);
    cyc(0, a, 0, 0, 0);
    @(negedge clk);
    chk(rdata, exp, what);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    rd_chk(0, 0, "R1 raw0 after reset");
    rd_chk(12, 0, "R1 mask2 after reset");
    rd_chk(22, 0, "R1 chen after reset");
    chk(32'(irq), 0, "R1 irq after reset");

    cur_req = "R2";   // transfer class ch1 (bit 1), error class ch3 (bit 19)
    cyc(0, 0, 0, 20'h80002, 0);
    rd_chk(0, 32'h2, "R2 raw transfer");
    rd_chk(4, 32'h8, "R2 raw error");
    chk(32'(irq), 0, "R2 masked irq");

    cur_req = "R4";
    cyc(1, 10, 32'h0202, 0, 0);
    cyc(1, 10, 32'h0C08, 0, 0);      // ch3 -> 1, ch2 -> 0
    cyc(1, 10, 32'h0001, 0, 0);      // no enable: ignored
    rd_chk(10, 32'hA, "R4 mask readback");
    cur_req = "R3";
    rd_chk(5, 32'h2, "R3 status transfer");
    cur_req = "R6";
    chk(32'(irq), 32'h1, "R6 irq_cls");
    chk(32'(any), 1, "R6 irq_any");
    cur_req = "R7";
    rd_chk(20, 32'h1, "R7 combined");

    cur_req = "R10";
    cyc(1, 0, 32'hF, 0, 0);
    cyc(1, 5, 32'hF, 0, 0);
    cyc(1, 20, 32'hF, 0, 0);
    rd_chk(0, 32'h2, "R10 raw unchanged");

    cur_req = "R5";
    cyc(1, 15, 32'h0, 0, 0);
    rd_chk(0, 32'h2, "R5 clear zero no effect");
    cyc(1, 15, 32'h2, 0, 0);
    rd_chk(0, 32'h0, "R5 cleared");
    chk(32'(irq), 0, "R5 irq dropped");
    cyc(1, 15, 32'h2, 20'h2, 0);
    rd_chk(0, 32'h2, "R5 event beats clear");

    cur_req = "R8";
    cyc(1, 21, 32'h1, 0, 0);
    rd_chk(21, 32'h1, "R8 enable read");
    cyc(1, 21, 32'hFFFE, 0, 0);
    rd_chk(21, 32'h0, "R8 disable read");

    cur_req = "R9";
    cyc(1, 22, 32'h0F0F, 0, 0);
    rd_chk(22, 32'hF, "R9 start all");
    cyc(1, 22, 32'h0100, 0, 0);
    rd_chk(22, 32'hE, "R9 stop ch0");
    cyc(0, 0, 0, 0, 4'h2);
    rd_chk(22, 32'hC, "R9 done clears ch1");
    cyc(1, 22, 32'h0404, 0, 4'h4);
    rd_chk(22, 32'hC, "R9 write beats done");

    cur_req = "R4";
    cyc(1, 10, 32'h0200, 0, 0);
    rd_chk(10, 32'h8, "R4 disable ch1");
    chk(32'(irq), 0, "R4 irq off after mask");

    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      cyc($urandom_range(0, 1) == 1, int'($urandom_range(0, 23)), $urandom,
          20'($urandom & $urandom & $urandom), 4'($urandom & $urandom));
    end
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule